// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible control face of one DMA channel. It holds four 32-bit words (channel control and status, the current memory address, a byte count and a spare base/test word) behind a simple word-wide register bus with a write strobe, a word address, write data and registered read data. The data movement engine sits beside it. That engine reports each finished transfer together with its byte length, and the block advances the address word by that length.

The control word mixes writable and protected bits. Its top bits always read as a fixed version code. A peripheral interrupt input sets and clears a pending flag. The system interrupt line is that flag gated by an enable bit. A write that sets the peripheral-reset bit produces a one-cycle reset pulse toward the peripheral. A level output mirrors the DMA-enable bit. An all-zero control write is turned into a FIFO-drain request. Writing the address word marks the channel as loaded.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset the control word reads 0xA0000000, the other three words read zero, and sys_irq, periph_rst_pulse and dma_en_out are low.
- R2: bus_addr[3:2] selects the word (0 control, 1 address, 2 count, 3 base/test). A write stores its data on the clock edge. bus_rdata shows the selected word as it stood before that edge, valid one cycle after the address is presented.
- R3: Control bits 31:25 and 2:0 (mask 0xFE000007) are protected. A control write leaves them unchanged and replaces only the other bits. The version pattern 0xA0000000 is always ORed into the stored word.
- R4: A write to the address word sets bit 26 (loaded) of the control word.
- R5: sys_irq equals pending (bit 0) AND interrupt enable (bit 4), registered. It therefore rises after a control write that sets enable while pending is set, and falls after a write that clears enable.
- R6: A rising edge on periph_irq sets pending. A falling edge clears it.
- R7: A control write with bit 7 set drives periph_rst_pulse high for exactly the next cycle.
- R8: Before storing, a control write with bit 7 clear and bit 6 (drain) set has bit 6 cleared. A control write of all zeros stores bit 6 set. With bit 7 set the value is stored as written.
- R9: dma_en_out follows control bit 9. It changes only when a write changes that bit, and rewriting the same value leaves it unchanged.
- R10: A xfer_done cycle adds xfer_len (zero-extended, modulo 2^32) to the address word.
- R11: When a bus write to the address word and xfer_done occur in the same cycle, the written value is stored and the length is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (4) | Byte address; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| periph_irq | input | 1 | Interrupt request from the peripheral |
| sys_irq | output | 1 | Gated interrupt to the system |
| periph_rst_pulse | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_out | output | 1 | DMA enable level to the peripheral |
| xfer_done | input | 1 | One peripheral transfer has completed |
| xfer_len | input | LEN_W (16) | Byte length of the completed transfer |

## Verification
The bench builds the block with its default values: a 4-bit byte address giving four words, and a 16-bit transfer length. With these, every word of the map is reachable by random bus traffic. Lengths up to 0xFFFF are large enough to carry the address word across its upper half-words, and an address written near 0xFFFFFFFF exercises the 32-bit wrap. Protected-bit handling, the drain rewrite and same-cycle collisions of address writes and transfer completion are reached both by directed writes and by random mixing of all inputs.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [WORD_W-1:0] CTL_VERSION = 32'hA000_0000;
  localparam logic [WORD_W-1:0] CTL_PROTECT = 32'hFE00_0007;

  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_PRST   = 7;
  localparam int unsigned B_TOMEM  = 8;
  localparam int unsigned B_DMAEN  = 9;
  localparam int unsigned B_LOADED = 26;

  localparam int unsigned IDX_CTL  = 0;
  localparam int unsigned IDX_ADDR = 1;

  // Rewrite rules applied to a control write value before masking.
  function automatic logic [WORD_W-1:0] ctl_rewrite(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    r = v;
    if (v[B_PRST]) begin
      r = v;
    end else if (v[B_DRAIN]) begin
      r[B_DRAIN] = 1'b0;
    end else if (v == '0) begin
      r[B_DRAIN] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/dma_word_reg.sv
module dma_word_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int unsigned W     = 32,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [W-1:0]     wdata,
  input  logic             done,
  input  logic [LEN_W-1:0] len,
  output logic [W-1:0]     q
);
  localparam int unsigned PAD = W - LEN_W;

  logic [W-1:0] len_ext;
  assign len_ext = {{PAD{1'b0}}, len};

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (we)   q <= wdata;
    else if (done) q <= q + len_ext;
  end

  // R10: completion advances the address by the length
  p_advance_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !we) |=> (q == $past(q) + $past(len_ext)));

  // R11: a bus write wins over a same-cycle completion
  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata)));
endmodule

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              set_loaded,
  input  logic              irq_in,
  output logic [WORD_W-1:0] ctl,
  output logic              sys_irq,
  output logic              rst_pulse,
  output logic              en_out
);
  logic              irq_prev;
  logic              irq_rise;
  logic              irq_fall;
  logic [WORD_W-1:0] wval;
  logic [WORD_W-1:0] nxt;

  assign irq_rise = irq_in && !irq_prev;
  assign irq_fall = !irq_in && irq_prev;
  assign wval     = ctl_rewrite(wdata);

  always_comb begin
    nxt = ctl;
    if (we)         nxt = (ctl & CTL_PROTECT) | (wval & ~CTL_PROTECT) | CTL_VERSION;
    if (set_loaded) nxt[B_LOADED] = 1'b1;
    if (irq_rise)      nxt[B_PEND] = 1'b1;
    else if (irq_fall) nxt[B_PEND] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= CTL_VERSION;
      irq_prev  <= 1'b0;
      sys_irq   <= 1'b0;
      rst_pulse <= 1'b0;
      en_out    <= 1'b0;
    end else begin
      ctl       <= nxt;
      irq_prev  <= irq_in;
      sys_irq   <= nxt[B_PEND] & nxt[B_IEN];
      rst_pulse <= we & wdata[B_PRST];
      en_out    <= nxt[B_DMAEN];
    end
  end

  // R3: version bits and fixed-zero protected bits never change
  p_version_r3: assert property (@(posedge clk) disable iff (rst)
    ((ctl & 32'hFA00_0006) == CTL_VERSION));

  // R3: a control write leaves the loaded flag untouched
  p_keep_loaded_r3: assert property (@(posedge clk) disable iff (rst)
    (we && !set_loaded) |=> (ctl[B_LOADED] == $past(ctl[B_LOADED])));

  // R6: peripheral request edges move the pending flag
  p_pend_set_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_in) |=> ctl[B_PEND]);
  p_pend_clr_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_in) |=> !ctl[B_PEND]);

  // R7: a write with the reset bit pulses for one cycle
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[B_PRST]) |=> rst_pulse);
  p_pulse_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !we |=> !rst_pulse);

  // R9: enable output takes the written bit, else holds
  p_en_write_r9: assert property (@(posedge clk) disable iff (rst)
    we |=> (en_out == $past(wdata[B_DMAEN])));
  p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(en_out));

  // R5: interrupt line off whenever enable is off
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (we && !wdata[B_IEN]) |=> !sys_irq);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              periph_irq,
  output logic              sys_irq,
  output logic              periph_rst_pulse,
  output logic              dma_en_out,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len
);
  localparam int unsigned SEL_W  = ADDR_W - 2;
  localparam int unsigned NWORDS = 1 << SEL_W;

  logic [SEL_W-1:0]             sel;
  logic [NWORDS-1:0]            wr_hit;
  logic [NWORDS-1:0][WORD_W-1:0] word_q;

  assign sel = bus_addr[ADDR_W-1:2];

  always_comb begin
    wr_hit = '0;
    wr_hit[sel] = bus_we;
  end

  dma_ctl_reg u_ctl (
    .clk        (clk),
    .rst        (rst),
    .we         (wr_hit[IDX_CTL]),
    .wdata      (bus_wdata),
    .set_loaded (wr_hit[IDX_ADDR]),
    .irq_in     (periph_irq),
    .ctl        (word_q[IDX_CTL]),
    .sys_irq    (sys_irq),
    .rst_pulse  (periph_rst_pulse),
    .en_out     (dma_en_out)
  );

  dma_addr_reg #(.W(WORD_W), .LEN_W(LEN_W)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_hit[IDX_ADDR]),
    .wdata (bus_wdata),
    .done  (xfer_done),
    .len   (xfer_len),
    .q     (word_q[IDX_ADDR])
  );

  for (genvar g = 2; g < NWORDS; g++) begin : g_plain
    dma_word_reg #(.W(WORD_W)) u_word (
      .clk (clk),
      .rst (rst),
      .we  (wr_hit[g]),
      .d   (bus_wdata),
      .q   (word_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= word_q[sel];
  end

  // R4: an address write marks the channel loaded
  p_loaded_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == SEL_W'(IDX_ADDR)) |=> word_q[IDX_CTL][B_LOADED]);

  // R2: read data is the word selected on the previous cycle
  p_read_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_we) && !$past(xfer_done) && $stable(periph_irq))
      |-> (bus_rdata == $past(word_q[sel]) || $past(rst)));
endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        periph_irq = 1'b0;
  logic        sys_irq, periph_rst_pulse, dma_en_out;
  logic        xfer_done = 1'b0;
  logic [15:0] xfer_len = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_irq(periph_irq),
    .sys_irq(sys_irq), .periph_rst_pulse(periph_rst_pulse),
    .dma_en_out(dma_en_out), .xfer_done(xfer_done), .xfer_len(xfer_len)
  );

  // Behavioural reference model
  bit [31:0] m_w [4];
  bit [31:0] m_rd;
  bit        m_irq, m_pulse, m_en, m_prev;

  always @(posedge clk) begin
    bit [31:0] v;
    int idx;
    if (rst) begin
      m_w[0] = 32'hA000_0000; m_w[1] = 0; m_w[2] = 0; m_w[3] = 0;
      m_rd = 0; m_irq = 0; m_pulse = 0; m_en = 0; m_prev = 0;
    end else begin
      idx = int'(bus_addr[3:2]);
      m_rd = m_w[idx];
      m_pulse = 0;
      if (bus_we && idx == 0) begin
        v = bus_wdata;
        if (v[7]) m_pulse = 1;
        else if (v[6]) v[6] = 0;
        else if (v == 0) v = 32'h40;
        m_w[0] = (m_w[0] & 32'hFE00_0007) | (v & ~32'hFE00_0007) | 32'hA000_0000;
      end
      if (bus_we && idx == 1) begin
        m_w[1] = bus_wdata;
        m_w[0][26] = 1;
      end else if (xfer_done) begin
        m_w[1] = m_w[1] + {16'h0, xfer_len};
      end
      if (bus_we && idx >= 2) m_w[idx] = bus_wdata;
      if (periph_irq && !m_prev) m_w[0][0] = 1;
      else if (!periph_irq && m_prev) m_w[0][0] = 0;
      m_prev = periph_irq;
      m_irq = m_w[0][0] & m_w[0][4];
      m_en = m_w[0][9];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 rdata", bus_rdata, m_rd);
      check("R5 sys_irq", {31'b0, sys_irq}, {31'b0, m_irq});
      check("R7 pulse", {31'b0, periph_rst_pulse}, {31'b0, m_pulse});
      check("R9 dma_en", {31'b0, dma_en_out}, {31'b0, m_en});
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = 4'(idx << 2); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = 4'(idx << 2);
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic done_len(input logic [15:0] l);
    @(negedge clk);
    xfer_done = 1; xfer_len = l;
    @(negedge clk);
    xfer_done = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 sys_irq", {31'b0, sys_irq}, 0);
    check("R1 pulse", {31'b0, periph_rst_pulse}, 0);
    check("R1 dma_en", {31'b0, dma_en_out}, 0);
    rd(0, 32'hA000_0000, "R1 ctl");
    rd(1, 0, "R1 addr");
    rd(2, 0, "R1 count");
    rd(3, 0, "R1 base");
    // R2 word selection
    wr(2, 32'h1234_5678);
    wr(3, 32'hCAFE_F00D);
    rd(2, 32'h1234_5678, "R2 count");
    rd(3, 32'hCAFE_F00D, "R2 base");
    // R3 protected bits, R7 pulse, R9 enable
    @(negedge clk);
    bus_we = 1; bus_addr = 0; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_we = 0;
    check("R7 pulse after reset bit", {31'b0, periph_rst_pulse}, 1);
    check("R9 enable rises", {31'b0, dma_en_out}, 1);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, periph_rst_pulse}, 0);
    rd(0, 32'hA1FF_FFF8, "R3 masked write");
    wr(0, 32'h0000_0200);
    check("R9 rewrite keeps enable", {31'b0, dma_en_out}, 1);
    // R8 drain rewrites
    wr(0, 32'h0000_0040);
    check("R9 enable falls", {31'b0, dma_en_out}, 0);
    rd(0, 32'hA000_0000, "R8 drain cleared");
    wr(0, 32'h0);
    rd(0, 32'hA000_0040, "R8 zero becomes drain");
    wr(0, 32'h0000_00C0);
    rd(0, 32'hA000_00C0, "R8 reset keeps drain");
    // R6 / R5 interrupt gating
    @(negedge clk); periph_irq = 1;
    @(negedge clk);
    check("R5 masked irq", {31'b0, sys_irq}, 0);
    rd(0, 32'hA000_00C1, "R6 pending set");
    wr(0, 32'h0000_0010);
    check("R5 enable raises irq", {31'b0, sys_irq}, 1);
    @(negedge clk); periph_irq = 0;
    @(negedge clk);
    check("R6 fall clears irq", {31'b0, sys_irq}, 0);
    rd(0, 32'hA000_0010, "R6 pending cleared");
    @(negedge clk); periph_irq = 1;
    @(negedge clk);
    check("R5 pending with enable", {31'b0, sys_irq}, 1);
    wr(0, 32'h0);
    check("R5 disable lowers irq", {31'b0, sys_irq}, 0);
    rd(0, 32'hA000_0041, "R3 pending kept");
    // R4, R10, R11 address
    wr(1, 32'h0000_1000);
    rd(0, 32'hA400_0041, "R4 loaded set");
    done_len(16'h0020);
    done_len(16'h0100);
    rd(1, 32'h0000_1120, "R10 advance");
    @(negedge clk);
    bus_we = 1; bus_addr = 4'h4; bus_wdata = 32'h0000_5000;
    xfer_done = 1; xfer_len = 16'h0010;
    @(negedge clk);
    bus_we = 0; xfer_done = 0;
    rd(1, 32'h0000_5000, "R11 write wins");
    wr(1, 32'hFFFF_FFF0);
    done_len(16'h0020);
    rd(1, 32'h0000_0010, "R10 wrap");
    // Random traffic, compared with the model every cycle
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      bus_we = ($urandom_range(0, 3) == 0);
      bus_addr = 4'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: bus_wdata = 32'h0;
        1: bus_wdata = 32'h40;
        default: bus_wdata = $urandom;
      endcase
      periph_irq = ($urandom_range(0, 4) == 0) ? ~periph_irq : periph_irq;
      xfer_done = ($urandom_range(0, 2) == 0);
      xfer_len = 16'($urandom);
    end
    @(negedge clk);
    bus_we = 0; xfer_done = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule